// File: doc/BRIEF.md
# Set/Clear Interrupt Event Controller

This block gathers interrupt events from internal source lines and presents them to a host through a small synchronous register port. It keeps an event register and a mask register. Each of them is reached through two write addresses: one where every 1 bit turns a bit on, and one where every 1 bit turns a bit off. Zero bits in the written word do nothing. A software handler can therefore acknowledge exactly the events it has serviced and leave all others untouched, and it needs no read-modify-write.

Source lines are sampled once per clock, and each rising transition latches the matching event bit. Software can also raise events on purpose through the event set address. The top mask bit works as a global enable for the single level interrupt output. The remaining mask bits gate the event bits one for one. A read through the event set address returns the raw events. A read through the event clear address returns only the events that are enabled. Either mask address reads back the mask.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset the event register, the mask register and the interrupt output are all zero, and no stale source history can raise an event.
- R2: A 0-to-1 transition on source line i, sampled at a clock edge, sets event bit i at that edge. A source that stays high does not set the bit again after it has been cleared.
- R3: A write to the event set address (word 0) sets every event bit whose write data bit is 1. Event bits written with 0 keep their value.
- R4: A write to the event clear address (word 1) clears every event bit whose write data bit is 1. Bits written with 0 keep their value. No other address clears an event bit.
- R5: A write to the mask set address (word 2) sets the mask bits written with 1. A write to the mask clear address (word 3) clears them. Zero bits keep their value.
- R6: A read of word 0 returns the raw event register. A read of word 1 returns the event register ANDed bitwise with the mask register.
- R7: A read of word 2 or of word 3 returns the full mask register, including the master enable at bit 31.
- R8: The interrupt output is high exactly when mask bit 31 is 1 and some event bit i (i below 31) is 1 while mask bit i is also 1. With the master enable at 0 the output stays low.
- R9: If a rising source edge and a clear write hit the same event bit in the same cycle, the bit ends up set. The other bits named in the clear write are still cleared.
- R10: Event bit 31 has no source and no storage. It always reads 0, even after a set write with bit 31 at 1.
- R11: A falling transition on a source line never sets an event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| src_i | input | DATA_W-1 | Interrupt source lines, one per event bit |
| wen_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Suppose an event bit is stuck or was wrongly cleared. The raw read of word 0 shows it in the cycle after the edge or write that should have changed it. The interrupt output shows it at once whenever that bit is enabled. A wrong bit in the mask has two symptoms. The masked read of word 1 shows too many or too few bits, and the interrupt output behaves wrongly as soon as the master enable is set. If the stored source history is wrong, an event is either missed or raised twice from one held level. This shows up one cycle after the transition, or one cycle after a clear, as a wrong value at word 0.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

   typedef enum logic [1:0] {
      RSEL_NONE,
      RSEL_RAW,
      RSEL_MASKED,
      RSEL_MASK
   } rsel_e;

   function automatic rsel_e rsel_decode(input logic is_raw, input logic is_masked,
                                         input logic is_mask);
      if (is_raw)         return RSEL_RAW;
      else if (is_masked) return RSEL_MASKED;
      else if (is_mask)   return RSEL_MASK;
      else                return RSEL_NONE;
   endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int W = 31
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] hist_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) hist_q <= '0;
      else          hist_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~hist_q;
endmodule

// File: rtl/irq_sc_reg.sv
module irq_sc_reg #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] hw_set_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_d;

   always_comb begin
      q_d = q_o;
      if (set_we_i)      q_d = q_o | wdata_i;
      else if (clr_we_i) q_d = q_o & ~wdata_i;
      q_d = q_d | hw_set_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) q_o <= '0;
      else          q_o <= q_d;
   end
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
   import irq_sc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int EVT_SET_ADDR = 0,
   parameter int EVT_CLR_ADDR = 1,
   parameter int MSK_SET_ADDR = 2,
   parameter int MSK_CLR_ADDR = 3,
   parameter bit REG_IRQ      = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [DATA_W-2:0] src_i,
   input  logic              wen_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam int EVT_W   = DATA_W - 1;
   localparam int MB      = DATA_W - 1;
   localparam int ADDR_LIM = 1 << ADDR_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("irq_setclr_ctrl: DATA_W must be at least 2");
   end
   if (EVT_SET_ADDR >= ADDR_LIM || EVT_CLR_ADDR >= ADDR_LIM ||
       MSK_SET_ADDR >= ADDR_LIM || MSK_CLR_ADDR >= ADDR_LIM) begin : g_bad_addr
      $error("irq_setclr_ctrl: register address outside ADDR_W range");
   end
   if (EVT_SET_ADDR == EVT_CLR_ADDR || EVT_SET_ADDR == MSK_SET_ADDR ||
       EVT_SET_ADDR == MSK_CLR_ADDR || EVT_CLR_ADDR == MSK_SET_ADDR ||
       EVT_CLR_ADDR == MSK_CLR_ADDR || MSK_SET_ADDR == MSK_CLR_ADDR) begin : g_dup_addr
      $error("irq_setclr_ctrl: register addresses must be distinct");
   end

   logic hit_es, hit_ec, hit_ms, hit_mc;
   assign hit_es = (addr_i == ADDR_W'(EVT_SET_ADDR));
   assign hit_ec = (addr_i == ADDR_W'(EVT_CLR_ADDR));
   assign hit_ms = (addr_i == ADDR_W'(MSK_SET_ADDR));
   assign hit_mc = (addr_i == ADDR_W'(MSK_CLR_ADDR));

   logic [EVT_W-1:0]  rise;
   logic [EVT_W-1:0]  evt_q;
   logic [DATA_W-1:0] msk_q;

   irq_edge_det #(.W(EVT_W)) u_edge (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .lvl_i   (src_i),
      .rise_o  (rise)
   );

   irq_sc_reg #(.W(EVT_W)) u_evt (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .set_we_i (wen_i && hit_es),
      .clr_we_i (wen_i && hit_ec),
      .wdata_i  (wdata_i[EVT_W-1:0]),
      .hw_set_i (rise),
      .q_o      (evt_q)
   );

   irq_sc_reg #(.W(DATA_W)) u_msk (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .set_we_i (wen_i && hit_ms),
      .clr_we_i (wen_i && hit_mc),
      .wdata_i  (wdata_i),
      .hw_set_i ('0),
      .q_o      (msk_q)
   );

   logic [EVT_W-1:0] enabled;
   assign enabled = evt_q & msk_q[EVT_W-1:0];

   rsel_e rsel;
   assign rsel = rsel_decode(hit_es, hit_ec, hit_ms || hit_mc);

   always_comb begin
      unique case (rsel)
         RSEL_RAW:    rdata_o = {1'b0, evt_q};
         RSEL_MASKED: rdata_o = {1'b0, enabled};
         RSEL_MASK:   rdata_o = msk_q;
         default:     rdata_o = '0;
      endcase
   end

   logic irq_d;
   assign irq_d = msk_q[MB] && (|enabled);

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_n_i) irq_q <= 1'b0;
         else          irq_q <= irq_d;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_d;
   end
endmodule

// File: rtl/irq_setclr_chk.sv
module irq_setclr_chk #(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int EVT_CLR_ADDR = 1,
   parameter int MSK_SET_ADDR = 2,
   parameter int MSK_CLR_ADDR = 3,
   parameter bit REG_IRQ      = 1'b0
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic [DATA_W-2:0] src_i,
   input logic              wen_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [DATA_W-2:0] evt_q,
   input logic [DATA_W-1:0] msk_q
);
   localparam int MB = DATA_W - 1;

   logic [DATA_W-2:0] src_prev;
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) src_prev <= '0;
      else          src_prev <= src_i;
   end
   logic [DATA_W-2:0] up_chk;
   assign up_chk = src_i & ~src_prev;

   logic clr_wr, msk_wr, msk_rd;
   assign clr_wr = wen_i && (addr_i == ADDR_W'(EVT_CLR_ADDR));
   assign msk_wr = wen_i && (addr_i == ADDR_W'(MSK_SET_ADDR) || addr_i == ADDR_W'(MSK_CLR_ADDR));
   assign msk_rd = (addr_i == ADDR_W'(MSK_SET_ADDR) || addr_i == ADDR_W'(MSK_CLR_ADDR));

   // R2 and R9: a sampled rising edge always leaves its event bit set
   assert_edge_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (|up_chk) |=> ((evt_q & $past(up_chk)) == $past(up_chk)));

   // R4: event bits only drop after a clear write
   assert_clear_path_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !clr_wr |=> ((evt_q & ~$past(evt_q)) == (evt_q ^ $past(evt_q))));

   // R5: mask holds its value without a mask write
   assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !msk_wr |=> $stable(msk_q));

   // R7: mask addresses read back the mask
   assert_mask_read_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      msk_rd |-> (rdata_o == msk_q));

   if (REG_IRQ) begin : g_reg
      // R8: output high implies the master enable was set
      assert_master_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         irq_o |-> $past(msk_q[MB]));
   end else begin : g_comb
      // R8: output high implies master enable and an enabled event
      assert_master_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         irq_o |-> (msk_q[MB] && |(evt_q & msk_q[MB-1:0])));
   end
endmodule

bind irq_setclr_ctrl irq_setclr_chk #(
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .EVT_CLR_ADDR (EVT_CLR_ADDR),
   .MSK_SET_ADDR (MSK_SET_ADDR),
   .MSK_CLR_ADDR (MSK_CLR_ADDR),
   .REG_IRQ      (REG_IRQ)
) u_chk (
   .clk_i   (clk_i),
   .rst_n_i (rst_n_i),
   .src_i   (src_i),
   .wen_i   (wen_i),
   .addr_i  (addr_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .evt_q   (evt_q),
   .msk_q   (msk_q)
);

// File: tb/tb_irq_setclr_ctrl.sv
module tb_irq_setclr_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [30:0] src = '0;
   logic        wen = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   always #4 clk = ~clk;

   irq_setclr_ctrl dut (
      .clk_i(clk), .rst_n_i(rst_n), .src_i(src), .wen_i(wen),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string r);
      item_t it;
      @(negedge clk);
      wen = 1'b0; addr = a;
      it.is_irq = 1'b0; it.exp = e; it.req = r;
      sb.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string r);
      item_t it;
      @(negedge clk);
      wen = 1'b0;
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = r;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wen = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wen = 1'b0;
   endtask

   task automatic drive_src(input logic [30:0] v);
      @(negedge clk);
      src = v;
      @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(4'd0, 32'h0, "R1 event after reset");
      rd(4'd2, 32'h0, "R1 mask after reset");
      chk_irq(1'b0, "R1 irq after reset");
      // R3 set semantics
      wr(4'd0, 32'h0000_00F0);
      rd(4'd0, 32'h0000_00F0, "R3 set bits");
      wr(4'd0, 32'h0000_0001);
      rd(4'd0, 32'h0000_00F1, "R3 zeros keep bits");
      // R4 clear semantics
      wr(4'd1, 32'h0000_0030);
      rd(4'd0, 32'h0000_00C1, "R4 clear bits");
      wr(4'd3, 32'hFFFF_FFFF);
      rd(4'd0, 32'h0000_00C1, "R4 mask write does not clear events");
      rd(4'd3, 32'h0, "R5 mask clear all");
      // R5 / R7 / R6 / R8
      wr(4'd2, 32'h8000_0041);
      rd(4'd2, 32'h8000_0041, "R7 mask via set address");
      rd(4'd3, 32'h8000_0041, "R7 mask via clear address");
      rd(4'd1, 32'h0000_0041, "R6 masked read");
      rd(4'd0, 32'h0000_00C1, "R6 raw read");
      chk_irq(1'b1, "R8 enabled event raises irq");
      wr(4'd3, 32'h8000_0000);
      rd(4'd2, 32'h0000_0041, "R5 mask clear master");
      chk_irq(1'b0, "R8 master off gates irq");
      wr(4'd2, 32'h8000_0000);
      chk_irq(1'b1, "R8 master back on");
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd0, 32'h0, "R4 clear all");
      chk_irq(1'b0, "R8 no events");
      // R2 / R11 edges
      drive_src(31'h0000_0020);
      rd(4'd0, 32'h0000_0020, "R2 rising edge latches");
      wr(4'd1, 32'h0000_0020);
      drive_src(31'h0000_0020);
      rd(4'd0, 32'h0, "R2 held level does not re-set");
      drive_src(31'h0);
      rd(4'd0, 32'h0, "R11 falling edge ignored");
      // R9 edge and clear in one cycle
      wr(4'd0, 32'h0000_000C);
      @(negedge clk);
      wen = 1'b1; addr = 4'd1; wdata = 32'h0000_000C; src = 31'h0000_0008;
      @(posedge clk);
      #1 wen = 1'b0;
      rd(4'd0, 32'h0000_0008, "R9 edge wins over clear");
      drive_src(31'h0);
      wr(4'd1, 32'hFFFF_FFFF);
      // R10 top event bit
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, 32'h7FFF_FFFF, "R10 bit 31 reads zero");
      rd(4'd1, 32'h0000_0041, "R6 masked read all events");
      wr(4'd1, 32'hFFFF_FFFF);
      // R2 multi-bit edges, R8 mask enable
      drive_src(31'h0001_0002);
      rd(4'd0, 32'h0001_0002, "R2 several edges");
      rd(4'd1, 32'h0, "R6 masked read disabled bits");
      chk_irq(1'b0, "R8 unmasked event only");
      wr(4'd2, 32'h0000_0002);
      chk_irq(1'b1, "R8 mask enable raises irq");
      rd(4'd1, 32'h0000_0002, "R6 masked read after enable");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule